// File: doc/BRIEF.md
# Strobed LSB-First Serial Command Port

This block is the target side of a three-wire-plus-strobe serial link into a display controller. A host pulls an active-low framing line low, then toggles a shift clock while presenting bits on a data-in line. The block runs entirely on a fast system clock. It passes every pin through a two-flop synchroniser and detects edges on the synchronised copies. It raises a single-cycle interrupt pulse when a frame opens. It gathers incoming bits into bytes, least significant bit first, and marks the opening byte of each frame as a command and every later byte as data.

For reads, the surrounding logic supplies a byte on a parallel input and pulses a load strobe. The block then sends that byte back on an open-drain output, also least significant bit first. It changes the output on falling shift-clock edges so the host can sample it on rising edges. The output pin is represented by a single pull-low enable. The pad either sinks current or floats, and an external pull-up supplies the high level.

Top module: `serial_cmd_port`

## Requirements
- R1: A falling edge on `frame_ni` produces `irq_o` high for exactly one system clock cycle.
- R2: The first byte completed after `frame_ni` falls is delivered with `rx_cmd_o` = 1. Every further byte in the same frame is delivered with `rx_cmd_o` = 0.
- R3: While `frame_ni` is high, shift-clock edges have no effect: `rx_vld_o` stays low and `sdo_low_o` stays 0.
- R4: `sdi_i` is sampled on each rising edge of `sck_i`, and the first sampled bit becomes bit 0. After the eighth sampled bit, `rx_vld_o` pulses for one cycle with the assembled byte on `rx_byte_o`.
- R5: If `frame_ni` rises before eight bits have arrived, the partial bits are dropped and no valid pulse is produced. The next frame starts again from bit 0 with the command flag set.
- R6: After `rd_load_i` captures `rd_byte_i`, each falling `sck_i` edge inside the frame presents the next bit, starting with bit 0. Between falling edges the output is held steady. After eight bits the line is released.
- R7: `sdo_low_o` = 1 means the pad sinks to low and 0 means it is released, so the line is never driven high. The line is released out of reset, right after a load, and whenever `frame_ni` is high.
- R8: Every pin event reaches the outputs three system clock edges after the first edge that samples it: two synchroniser stages plus one output register. `sck_i` must toggle no faster than one quarter of the system clock rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Transfer framing strobe, active low |
| sck_i | input | 1 | Serial shift clock, idles high |
| sdi_i | input | 1 | Serial data in |
| rd_load_i | input | 1 | Pulse that loads `rd_byte_i` for transmission |
| rd_byte_i | input | 8 | Byte to send back to the host |
| irq_o | output | 1 | One-cycle pulse on frame start |
| rx_vld_o | output | 1 | One-cycle pulse when a byte has been received |
| rx_cmd_o | output | 1 | Received byte is the frame's command byte |
| rx_byte_o | output | 8 | Received byte |
| sdo_low_o | output | 1 | Open-drain data-out enable: 1 sinks the pad low |

## Verification
Every result of a pin event (the interrupt, the byte-valid pulse with its flag and value, and a new output bit) is due on the third rising system clock edge after the edge that first samples the pin change. Inputs are changed on falling system clock edges. A behavioural model in the bench keeps a short history of sampled pin values and applies each event three edges late. Every output is compared against the model on each falling edge, half a cycle after it settles. The frame-start delay is also checked by a directed test: the interrupt must be absent after two edges and present after the third. Read-back bits are taken at each rising shift-clock edge, four system cycles after the falling edge that launched them.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef struct packed {
    logic frame_n;
    logic sck;
    logic sdi;
  } scp_pins_t;

  localparam scp_pins_t PINS_IDLE = '{frame_n: 1'b1, sck: 1'b1, sdi: 1'b1};
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] ff_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) ff_q[i] <= RST_VAL;
    end else begin
      ff_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/scp_rx.sv
module scp_rx #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic         rise_i,
  input  logic         sdi_i,
  output logic         vld_o,
  output logic         is_cmd_o,
  output logic [W-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(W);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             first_q;
  logic [W-1:0]     sh_next;

  assign sh_next = {sdi_i, sh_q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      first_q  <= 1'b1;
      vld_o    <= 1'b0;
      is_cmd_o <= 1'b0;
      data_o   <= '0;
    end else begin
      vld_o <= 1'b0;
      if (!active_i) begin
        // idle frame: drop partial byte, rearm command tag
        cnt_q   <= '0;
        first_q <= 1'b1;
      end else if (rise_i) begin
        sh_q <= sh_next;
        if (cnt_q == CNT_W'(W-1)) begin
          cnt_q    <= '0;
          vld_o    <= 1'b1;
          data_o   <= sh_next;
          is_cmd_o <= first_q;
          first_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_no_rx_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(active_i) |-> !vld_o);
  assert_vld_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
  assert_cmd_needs_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !is_cmd_o) |-> $past(active_i));
endmodule

// File: rtl/scp_tx.sv
module scp_tx #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic         fall_i,
  input  logic         load_i,
  input  logic [W-1:0] byte_i,
  output logic         drv_low_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '1;
      drv_low_o <= 1'b0;
    end else if (load_i) begin
      sh_q      <= byte_i;
      drv_low_o <= 1'b0;
    end else if (!active_i) begin
      drv_low_o <= 1'b0;
    end else if (fall_i) begin
      // ones refill so the line releases once the byte is out
      drv_low_o <= ~sh_q[0];
      sh_q      <= {1'b1, sh_q[W-1:1]};
    end
  end

  assert_release_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(active_i) |-> !drv_low_o);
  assert_release_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> !drv_low_o);
  assert_hold_between_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active_i) && !$past(fall_i) && !$past(load_i)) |-> $stable(drv_low_o));
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              rd_load_i,
  input  logic [DATA_W-1:0] rd_byte_i,
  output logic              irq_o,
  output logic              rx_vld_o,
  output logic              rx_cmd_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sdo_low_o
);
  import scp_pkg::*;

  localparam int unsigned PIN_W = $bits(scp_pins_t);

  scp_pins_t pins_raw, pins_s;
  logic [PIN_W-1:0] sync_q;
  logic frame_d_q, sck_d_q;
  logic sck_rise, sck_fall, frame_fall, active;

  assign pins_raw = '{frame_n: frame_ni, sck: sck_i, sdi: sdi_i};

  scp_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (sync_q)
  );

  assign pins_s = scp_pins_t'(sync_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_d_q <= PINS_IDLE.frame_n;
      sck_d_q   <= PINS_IDLE.sck;
      irq_o     <= 1'b0;
    end else begin
      frame_d_q <= pins_s.frame_n;
      sck_d_q   <= pins_s.sck;
      irq_o     <= frame_fall;
    end
  end

  assign active     = ~pins_s.frame_n;
  assign frame_fall = frame_d_q & ~pins_s.frame_n;
  assign sck_rise   = ~sck_d_q & pins_s.sck;
  assign sck_fall   = sck_d_q & ~pins_s.sck;

  scp_rx #(.W(DATA_W)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .rise_i  (sck_rise),
    .sdi_i   (pins_s.sdi),
    .vld_o   (rx_vld_o),
    .is_cmd_o(rx_cmd_o),
    .data_o  (rx_byte_o)
  );

  scp_tx #(.W(DATA_W)) i_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .fall_i   (sck_fall),
    .load_i   (rd_load_i),
    .byte_i   (rd_byte_i),
    .drv_low_o(sdo_low_o)
  );

  assert_irq_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_irq_on_open_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> active);
endmodule

// File: tb/test_serial_cmd_port.sv
module test_serial_cmd_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, sck = 1'b1, sdi = 1'b1;
  logic rd_load = 1'b0;
  logic [7:0] rd_byte = '0;
  logic irq, vld, cmd, sdo_low;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  serial_cmd_port i_serial_cmd_port (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .sck_i(sck), .sdi_i(sdi),
    .rd_load_i(rd_load), .rd_byte_i(rd_byte), .irq_o(irq), .rx_vld_o(vld),
    .rx_cmd_o(cmd), .rx_byte_o(rx_byte), .sdo_low_o(sdo_low)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference: pin history, effects land three edges after sampling
  bit h_frame[3], h_sck[3], h_sdi[3];
  bit m_irq, m_vld, m_cmd, m_first, m_drv;
  int m_cnt, m_acc, m_byte, m_tx, m_tx_idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin h_frame[i] = 1; h_sck[i] = 1; h_sdi[i] = 1; end
      m_irq = 0; m_vld = 0; m_cmd = 0; m_first = 1; m_drv = 0;
      m_cnt = 0; m_acc = 0; m_byte = 0; m_tx = 0; m_tx_idx = 8;
    end else begin
      m_irq = h_frame[2] && !h_frame[1];
      m_vld = 0;
      if (h_frame[1]) begin
        m_cnt = 0; m_acc = 0; m_first = 1;
      end else if (h_sck[1] && !h_sck[2]) begin
        m_acc = m_acc | (int'(h_sdi[1]) << m_cnt);
        m_cnt++;
        if (m_cnt == 8) begin
          m_vld = 1; m_byte = m_acc; m_cmd = m_first;
          m_first = 0; m_cnt = 0; m_acc = 0;
        end
      end
      if (rd_load) begin
        m_tx = rd_byte; m_tx_idx = 0; m_drv = 0;
      end else if (h_frame[1]) begin
        m_drv = 0;
      end else if (!h_sck[1] && h_sck[2]) begin
        if (m_tx_idx < 8) begin m_drv = !m_tx[m_tx_idx]; m_tx_idx++; end
        else m_drv = 0;
      end
      for (int i = 2; i > 0; i--) begin
        h_frame[i] = h_frame[i-1]; h_sck[i] = h_sck[i-1]; h_sdi[i] = h_sdi[i-1];
      end
      h_frame[0] = frame_n; h_sck[0] = sck; h_sdi[0] = sdi;
    end
  end

  // per-cycle comparison and byte capture
  int n_got = 0;
  int got_byte[64];
  bit got_cmd[64];

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R1 irq", irq, m_irq);
      chk("R4 rx_vld", vld, m_vld);
      chk("R7 sdo_low", sdo_low, m_drv);
      if (vld && m_vld) begin
        chk("R2 rx_cmd", cmd, m_cmd);
        chk("R4 rx_byte", rx_byte, m_byte);
      end
      if (vld && n_got < 64) begin
        got_byte[n_got] = rx_byte; got_cmd[n_got] = cmd; n_got++;
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, output logic [7:0] rd);
    rd = '0;
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0; sdi = b[i];
      wait_clk(4);
      rd[i] = ~sdo_low;
      sck = 1'b1;
      wait_clk(4);
    end
  endtask

  task automatic open_frame();
    frame_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic close_frame();
    frame_n = 1'b1;
    wait_clk(6);
  endtask

  initial begin
    logic [7:0] rd;
    int base;
    bit seen_low;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    // reset state
    chk("R7 reset sdo", sdo_low, 0);
    chk("R4 reset vld", vld, 0);
    chk("R1 reset irq", irq, 0);

    // R3: clocking with the frame closed
    base = n_got;
    send_bits(8'hA5, 8, rd);
    wait_clk(6);
    chk("R3 idle bytes", n_got - base, 0);
    chk("R3 idle sdo", sdo_low, 0);

    // R8: interrupt latency from the strobe fall
    frame_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 irq early", irq, 0);
    @(posedge clk); @(negedge clk);
    chk("R8 irq due", irq, 1);
    wait_clk(3);

    // command then data bytes
    base = n_got;
    send_bits(8'h3C, 8, rd);
    send_bits(8'h81, 8, rd);
    send_bits(8'h00, 8, rd);
    wait_clk(4);
    close_frame();
    chk("R2 byte count", n_got - base, 3);
    chk("R2 first cmd", got_cmd[base], 1);
    chk("R4 first byte", got_byte[base], 8'h3C);
    chk("R2 second data", got_cmd[base+1], 0);
    chk("R4 second byte", got_byte[base+1], 8'h81);
    chk("R4 third byte", got_byte[base+2], 8'h00);

    // read back: R6
    open_frame();
    send_bits(8'h42, 8, rd);
    rd_byte = 8'hB6; rd_load = 1'b1;
    wait_clk(1);
    rd_load = 1'b0;
    wait_clk(1);
    chk("R7 after load", sdo_low, 0);
    send_bits(8'hFF, 8, rd);
    chk("R6 read byte", rd, 8'hB6);
    send_bits(8'h00, 8, rd);
    chk("R6 released after byte", rd, 8'hFF);
    close_frame();
    chk("R7 release on close", sdo_low, 0);

    // R5: partial byte then a fresh frame
    base = n_got;
    open_frame();
    send_bits(8'h07, 3, rd);
    close_frame();
    chk("R5 partial dropped", n_got - base, 0);
    open_frame();
    send_bits(8'h5A, 8, rd);
    wait_clk(4);
    close_frame();
    chk("R5 count", n_got - base, 1);
    chk("R5 cmd flag", got_cmd[base], 1);
    chk("R5 value", got_byte[base], 8'h5A);

    // R7: load while closed, then clock in a closed frame
    rd_byte = 8'h00; rd_load = 1'b1;
    wait_clk(1);
    rd_load = 1'b0;
    seen_low = 0;
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; wait_clk(4);
      if (sdo_low) seen_low = 1;
      sck = 1'b1; wait_clk(4);
    end
    chk("R7 no drive while closed", seen_low, 0);

    // second read of all-zero byte inside a frame: R6
    open_frame();
    send_bits(8'h99, 8, rd);
    chk("R6 zero byte", rd, 8'h00);
    close_frame();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule